// File: doc/BRIEF.md
# Receive Clock Frequency Lock Detector

This block watches a receive-side clock, either the one arriving with the line data or the one rebuilt by clock recovery, and decides whether its frequency is close enough to the local reference. The receive clock arrives as a single-cycle strobe that has already been synchronised into the reference domain, one strobe per receive period. The nominal strobe rate is 19.44 MHz.

The block counts strobes over a measurement window whose length is a fixed number of reference cycles. It compares the count with the count expected for the selected reference rate. The absolute deviation is checked against two limits derived from ppm parameters. A wide limit takes the lock flag down, and a narrow limit is needed before the flag comes back up. The result of each window is also output as a raw count, so that a supervisor can watch the drift.

The reference rate is picked by a 3-bit select. Each selection fixes the window length in reference cycles and the expected count. The selection also scales both limits, so the ppm meaning of each limit stays the same at every rate.

Top module: `rx_freq_lock_mon`

## Requirements
- R1: While `rst_n` is low, and after it is released, `locked` is 0 and `meas_count` is 0 until the first window closes.
- R2: `rate_sel` gives the window length in reference cycles and the expected count. The codes are: 0 → BASE cycles, expect BASE; 1 → 2·BASE, expect BASE; 2 → 8·BASE, expect 3·BASE; 3 → 4·BASE, expect BASE; 4 → 8·BASE, expect BASE. Codes 5 to 7 behave as code 0.
- R3: `meas_count` takes, one cycle after the last cycle of a window, the number of reference cycles in that window in which `rx_tick` was 1. It changes at no other time.
- R4: When unlocked, `locked` rises at the end of a window whose deviation |count − expected| is at most floor(expected·GAIN_PPM/10^6). Otherwise it stays 0. This includes the first window after reset.
- R5: When locked, `locked` stays 1 at the end of a window whose deviation is at most floor(expected·LOSE_PPM/10^6). Both limits are computed from the expected count of the selected rate.
- R6: When locked, `locked` falls at the end of a window whose deviation exceeds the lose limit.
- R7: If `rx_tick` stays at 0 for a whole window, `meas_count` becomes 0 and the flag drops or stays low.
- R8: A reference cycle in which `rate_sel` differs from the selection in use discards the partial count and starts a fresh window on the next cycle. That cycle's strobe is not counted. `locked` and `meas_count` keep their values across the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_tick | input | 1 | One-cycle strobe per receive clock period, already in the reference domain |
| rate_sel | input | 3 | Reference rate selection (encoding in R2) |
| locked | output | 1 | Frequency lock flag |
| meas_count | output | CNT_W | Strobe count of the last completed window |

## Verification
The strobe is produced by a phase accumulator, so each window carries an exact, known number of strobes. The patterns used are full rate, slightly slow, moderately slow, far too slow and silent. A deviation between the two limits is applied both while locked and while unlocked. The flag holds in the first case and stays low in the second, which separates hysteresis from a single threshold. The same absolute deviation is accepted at the 8/3 ratio but would break lock at the 1:1 ratio, which shows that the limits scale with the selection. A rate change in the middle of a window, after a burst of strobes, shows that the partial count is discarded rather than merged.

// File: rtl/rxl_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the receive lock detector: rate table and limit math.
// Assumes the strobe nominal rate is the lowest reference rate (ratio >= 1).
package rxl_pkg;

    localparam int SEL_W = 3;
    localparam int NUM_SEL = 1 << SEL_W;
    localparam longint unsigned PPM_SCALE = 64'd1000000;

    // Reference cycles per BASE unit of window for a selection code.
    function automatic longint unsigned ref_mult(input int unsigned sel);
        case (sel)
            1:       return 64'd2;
            2:       return 64'd8;
            3:       return 64'd4;
            4:       return 64'd8;
            default: return 64'd1;
        endcase
    endfunction

    // Expected strobes per BASE unit of window for a selection code.
    function automatic longint unsigned tick_mult(input int unsigned sel);
        case (sel)
            2:       return 64'd3;
            default: return 64'd1;
        endcase
    endfunction

    // Deviation limit in counts for a given expected count and ppm.
    function automatic longint unsigned ppm_limit(input longint unsigned expct,
                                                  input longint unsigned ppm);
        return (expct * ppm) / PPM_SCALE;
    endfunction

endpackage

// File: rtl/rxl_window_timer.sv
`timescale 1ns/1ps
// Measurement window timer in reference cycles.
// Flags the last cycle of each window; a restart request zeroes it and
// suppresses the end flag. Assumes win_len >= 2.
module rxl_window_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] win_len,
    output logic         win_end
);

    logic [W-1:0] tmr;

    assign win_end = !restart && (tmr == (win_len - W'(1)));

    // Advance the cycle position, wrapping at window end or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (restart || win_end) begin
            tmr <= '0;
        end else begin
            tmr <= tmr + W'(1);
        end
    end

endmodule

// File: rtl/rxl_tick_counter.sv
`timescale 1ns/1ps
// Counts receive strobes within the current window.
// total includes the strobe of the current cycle, so at window end it is
// the complete window count. Assumes the count cannot exceed 2^W - 1.
module rxl_tick_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         win_end,
    input  logic         tick,
    output logic [W-1:0] total
);

    logic [W-1:0] cnt;

    assign total = cnt + W'(tick);

    // Accumulate strobes; clear on window end or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || win_end) begin
            cnt <= '0;
        end else begin
            cnt <= total;
        end
    end

endmodule

// File: rtl/rxl_lock_judge.sv
`timescale 1ns/1ps
// Hysteresis lock decision, evaluated once per closed window.
// Assumes gain_lim <= lose_lim; limits and expected count are static
// while a window is open.
module rxl_lock_judge #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         win_end,
    input  logic [W-1:0] total,
    input  logic [W-1:0] exp_cnt,
    input  logic [W-1:0] lose_lim,
    input  logic [W-1:0] gain_lim,
    output logic         locked,
    output logic [W-1:0] meas
);

    logic [W-1:0] dev;

    // Absolute deviation of the closing count from the expected count.
    always_comb begin
        if (total >= exp_cnt) dev = total - exp_cnt;
        else                  dev = exp_cnt - total;
    end

    // Capture the count and move the lock flag at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            meas   <= '0;
        end else if (win_end) begin
            meas <= total;
            if (locked) begin
                if (dev > lose_lim) locked <= 1'b0;
            end else begin
                if (dev <= gain_lim) locked <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rx_freq_lock_mon.sv
`timescale 1ns/1ps
// Receive clock frequency lock detector (top).
// Counts synchronised receive strobes over a reference-timed window chosen
// by rate_sel and applies a wide drop / narrow regain limit to the count.
// Assumes rx_tick is at most one per reference cycle and already
// synchronous to clk.
module rx_freq_lock_mon
    import rxl_pkg::*;
#(
    parameter int unsigned BASE     = 65536,
    parameter int unsigned LOSE_PPM = 500,
    parameter int unsigned GAIN_PPM = 100,
    localparam int CNT_W = $clog2(8 * BASE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_tick,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             locked,
    output logic [CNT_W-1:0] meas_count
);

    logic [SEL_W-1:0] sel_q;
    logic             restart;
    logic             win_end;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] win_tab  [NUM_SEL];
    logic [CNT_W-1:0] exp_tab  [NUM_SEL];
    logic [CNT_W-1:0] lose_tab [NUM_SEL];
    logic [CNT_W-1:0] gain_tab [NUM_SEL];
    logic [CNT_W-1:0] cur_win, cur_exp, cur_lose, cur_gain;

    // Per-selection constants: window length, expected count, limits.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_rate
        localparam longint unsigned EXPV = longint'(BASE) * tick_mult(g);
        assign win_tab[g]  = CNT_W'(longint'(BASE) * ref_mult(g));
        assign exp_tab[g]  = CNT_W'(EXPV);
        assign lose_tab[g] = CNT_W'(ppm_limit(EXPV, longint'(LOSE_PPM)));
        assign gain_tab[g] = CNT_W'(ppm_limit(EXPV, longint'(GAIN_PPM)));
    end

    // Selection in use; a mismatch with the input marks a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= rate_sel;
    end

    assign restart = (rate_sel != sel_q);

    // Pick the constants of the selection in use.
    always_comb begin
        cur_win  = win_tab[sel_q];
        cur_exp  = exp_tab[sel_q];
        cur_lose = lose_tab[sel_q];
        cur_gain = gain_tab[sel_q];
    end

    rxl_window_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .win_len (cur_win),
        .win_end (win_end)
    );

    rxl_tick_counter #(.W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .win_end (win_end),
        .tick    (rx_tick),
        .total   (total)
    );

    rxl_lock_judge #(.W(CNT_W)) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_end  (win_end),
        .total    (total),
        .exp_cnt  (cur_exp),
        .lose_lim (cur_lose),
        .gain_lim (cur_gain),
        .locked   (locked),
        .meas     (meas_count)
    );

endmodule

// File: rtl/rx_freq_lock_mon_chk.sv
`timescale 1ns/1ps
// Property checker for the lock detector, bound to the top module.
// Recomputes deviation and limits from the reported count and selection.
module rx_freq_lock_mon_chk
    import rxl_pkg::*;
#(
    parameter int unsigned BASE     = 65536,
    parameter int unsigned LOSE_PPM = 500,
    parameter int unsigned GAIN_PPM = 100,
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] rate_sel,
    input logic [SEL_W-1:0] sel_q,
    input logic             win_end,
    input logic             locked,
    input logic [CNT_W-1:0] meas_count
);

    longint unsigned exp_v, dev_v, lose_v, gain_v;

    // Deviation of the reported count for the selection in use.
    always_comb begin
        exp_v  = longint'(BASE) * tick_mult(int'(sel_q));
        dev_v  = (longint'(meas_count) >= exp_v) ? longint'(meas_count) - exp_v
                                                 : exp_v - longint'(meas_count);
        lose_v = ppm_limit(exp_v, longint'(LOSE_PPM));
        gain_v = ppm_limit(exp_v, longint'(GAIN_PPM));
    end

    // R3
    hold_between_windows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> ($stable(locked) && $stable(meas_count)));

    // R4
    acquire_within_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (dev_v <= gain_v));

    // R6
    drop_beyond_lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> (dev_v > lose_v));

    // R8
    rate_change_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != sel_q) |=> ($stable(locked) && $stable(meas_count)));

endmodule

bind rx_freq_lock_mon rx_freq_lock_mon_chk #(
    .BASE(BASE), .LOSE_PPM(LOSE_PPM), .GAIN_PPM(GAIN_PPM), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .sel_q      (sel_q),
    .win_end    (win_end),
    .locked     (locked),
    .meas_count (meas_count)
);

// File: tb/rx_freq_lock_mon_tb.sv
`timescale 1ns/1ps
// Directed bench: a phase accumulator makes exact strobe counts per window.
// Scaled parameters: BASE 1024, lose 20000 ppm, regain 4000 ppm.
// Limits at 1:1 are lose 20 and regain 4; at the 8/3 ratio they are 61 and 12.
module rx_freq_lock_mon_tb;

    localparam int unsigned BASE = 1024;
    localparam int CNT_W = $clog2(8 * BASE + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_tick = 1'b0;
    logic [2:0]       rate_sel = 3'd0;
    logic             locked;
    logic [CNT_W-1:0] meas_count;

    int n_chk = 0;
    int n_fail = 0;
    int acc = 0;

    always #2.5 clk = ~clk;

    rx_freq_lock_mon #(.BASE(BASE), .LOSE_PPM(20000), .GAIN_PPM(4000)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rate_sel(rate_sel),
        .locked(locked), .meas_count(meas_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Drive n cycles of strobes at rate inc/65536; returns strobes driven.
    task automatic drive(input int n, input int inc, output int ticks);
        ticks = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc += inc;
            if (acc >= 65536) begin
                acc -= 65536;
                rx_tick = 1'b1;
                ticks++;
            end else begin
                rx_tick = 1'b0;
            end
        end
    endtask

    // One full window, then check count and flag just after the closing edge.
    task automatic run_window(input int win, input int inc, input bit exp_lock,
                              input string req);
        int t;
        drive(win, inc, t);
        @(posedge clk);
        #1;
        check(int'(meas_count) == t, {req, " count"}, int'(meas_count), t);
        check(locked == exp_lock, {req, " lock"}, int'(locked), int'(exp_lock));
    endtask

    // Change selection; outputs must hold over the restart cycle (R8).
    task automatic switch_rate(input logic [2:0] sel);
        logic [CNT_W-1:0] m0;
        logic             l0;
        m0 = meas_count;
        l0 = locked;
        @(negedge clk);
        rate_sel = sel;
        rx_tick = 1'b1;
        @(posedge clk);
        #1;
        check(meas_count == m0, "R8 count held", int'(meas_count), int'(m0));
        check(locked == l0, "R8 lock held", int'(locked), int'(l0));
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        #1;
        check(locked == 1'b0, "R1 lock in reset", int'(locked), 0);
        check(meas_count == '0, "R1 count in reset", int'(meas_count), 0);
        rst_n = 1'b1;
        repeat (BASE - 1) @(posedge clk);
        #1;
        check(locked == 1'b0, "R1 lock before first window", int'(locked), 0);
        check(meas_count == '0, "R1 count before first window", int'(meas_count), 0);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic test_hysteresis();
        run_window(BASE, 64768, 1'b0, "R4 first window dev12 stays low");
        run_window(BASE, 65536, 1'b1, "R3 R4 full rate acquires");
        run_window(BASE, 64768, 1'b1, "R5 dev12 holds");
        run_window(BASE, 63872, 1'b0, "R6 dev26 drops");
        run_window(BASE, 64768, 1'b0, "R4 dev12 no regain");
        run_window(BASE, 65408, 1'b1, "R4 dev2 regains");
    endtask

    task automatic test_stopped();
        run_window(BASE, 0, 1'b0, "R7 silent window");
        run_window(BASE, 65536, 1'b1, "R4 relock after silence");
    endtask

    task automatic test_rate_change();
        int t;
        drive(300, 65536, t);
        switch_rate(3'd1);
        run_window(2 * BASE, 32768, 1'b1, "R8 R2 fresh window at sel 1");
    endtask

    task automatic test_ratio_scaling();
        switch_rate(3'd2);
        run_window(8 * BASE, 24576, 1'b1, "R2 sel 2 nominal");
        run_window(8 * BASE, 24256, 1'b1, "R5 sel 2 dev40 held");
        run_window(8 * BASE, 24016, 1'b0, "R6 sel 2 dev70 drops");
    endtask

    task automatic test_other_codes();
        switch_rate(3'd5);
        run_window(BASE, 65536, 1'b1, "R2 code 5 as code 0");
        switch_rate(3'd3);
        run_window(4 * BASE, 16384, 1'b1, "R2 sel 3");
        switch_rate(3'd4);
        run_window(8 * BASE, 8192, 1'b1, "R2 sel 4");
    endtask

    initial begin
        test_reset();
        test_hysteresis();
        test_stopped();
        test_rate_change();
        test_ratio_scaling();
        test_other_codes();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule